// File: doc/BRIEF.md
# Host/Controller Doorbell Register Window

This block is the device-side register window that a host processor and an embedded storage controller use to signal each other. The host reaches it through a simple 32-bit register bus: it rings inbound doorbells to hand work to the controller, reads and acknowledges outbound status flags raised by the controller, gates its own interrupt line with a two-bit mask, reads an error report and a completed-command status word, and writes a 64-bit command mailbox address. Every writable register has one address that sets bits and another that clears them. A bit written as 0 is never touched.

The controller side sees the latched inbound requests as plain outputs and consumes them with per-bit acknowledge pulses. It raises outbound flags, posts command status and error reports, and ends the power-on initialization phase through dedicated input pulses. All active register bits sit at bit 24 and above. The error report shares its read address with the outbound doorbell, and one clear pattern both acknowledges outbound flags and dismisses a pending error.

Top module: `dbr_regwin`

## Requirements
- R1: After reset the mask reads 0x03000000 at 0x22C (both sources disabled), the inbound doorbell reads 0x02000000 at 0x214 (initialization in progress), the outbound/error word at 0x224 reads 0, no inbound request is pending and irq_o is low.
- R2: A host write to 0x214 sets the inbound request bits where wdata[28:24] is 1 (24 mailbox command, 25 status acknowledge, 26 interrupt request, 27 controller reset, 28 memory-mailbox command), presented on ib_req_o[4:0]. A write to 0x218 clears the bits written as 1. A read of 0x214 returns bit 24 = mailbox full (request bit 0 pending) and bit 25 = initialization in progress.
- R3: A pulse on ctl_ib_ack_i[k] clears inbound request bit k. A host set of the same bit in the same cycle wins.
- R4: The initialization-in-progress flag drops one cycle after ctl_init_done_i and stays low until reset.
- R5: Outbound bit 24 (mailbox status available) and bit 25 (memory-mailbox status available) are set by ctl_ob_set_i[1:0] or by a host write of 1s to 0x224, and are cleared by a host write of 1s to 0x228. They read at 0x224 bits 25:24, and a controller set wins over a host clear in the same cycle.
- R6: Writing 1s at 0x22C bits 25:24 sets mask bits (disables sources), writing 1s at 0x230 clears them (enables sources), and 0x22C reads the mask at bits 25:24.
- R7: irq_o is high exactly when some outbound bit is set while its mask bit is clear. 0x208 reads those unmasked pending bits at bits 25:24.
- R8: ctl_err_post_i sets the error-pending flag (read at 0x224 bit 29) and latches two parameter bytes that read at 0x510 as byte 0 = ctl_err_p0_i and byte 1 = ctl_err_p1_i, upper half zero. A write to 0x228 with bits 25:24 both 1 (0x03000000) dismisses the error, a write with only one of them does not, and a new post in the same cycle wins.
- R9: Writes to 0x510 and 0x514 load the low and high words of mbox_addr_o[63:0]. 0x514 reads back the high word.
- R10: ctl_cst_post_i latches a 16-bit command identifier and a 16-bit status that read at 0x518 as {status, identifier}, and it also sets outbound bit 24.
- R11: Read data appears on host_rdata_o in the cycle after host_rd_i and is 0 for any address outside the readable set (0x208, 0x214, 0x224, 0x22C, 0x510, 0x514, 0x518). Writes to read-only or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | AW | Host byte address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered host read data |
| irq_o | output | 1 | Interrupt to host |
| ib_req_o | output | 5 | Latched inbound requests |
| ctl_ib_ack_i | input | 5 | Controller consumes inbound requests |
| init_busy_o | output | 1 | Initialization in progress |
| ctl_init_done_i | input | 1 | Controller ends initialization |
| ctl_ob_set_i | input | 2 | Controller raises outbound flags |
| ctl_cst_post_i | input | 1 | Controller posts command status |
| ctl_cst_id_i | input | 16 | Posted command identifier |
| ctl_cst_code_i | input | 16 | Posted command status |
| ctl_err_post_i | input | 1 | Controller posts an error |
| ctl_err_p0_i | input | 8 | Error parameter byte 0 |
| ctl_err_p1_i | input | 8 | Error parameter byte 1 |
| mbox_addr_o | output | 64 | Command mailbox bus address |

## Verification
The bench goes after same-cycle collisions: a host ring against a controller acknowledge of the same inbound bit, and a controller flag against a host clear of it. A design with the wrong priority drops a request or loses a status flag. It also aims at the shared 0x228 clear pattern, where a design that dismisses the error on a single acknowledge bit loses error reports. It covers the aliased 0x510 address too, where a design that returns the mailbox word instead of the parameter bytes gives the host garbage error detail. Random mixes of partial-bit set and clear writes catch any register that disturbs bits written as 0, and mask toggling with flags pending shows an interrupt line that ignores the mask or lags behind it.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    // Register offsets inside the window
    localparam int unsigned OFF_IRQ_STAT = 32'h208;
    localparam int unsigned OFF_IB_SET   = 32'h214;
    localparam int unsigned OFF_IB_CLR   = 32'h218;
    localparam int unsigned OFF_OB_SET   = 32'h224;
    localparam int unsigned OFF_OB_CLR   = 32'h228;
    localparam int unsigned OFF_MSK_SET  = 32'h22C;
    localparam int unsigned OFF_MSK_CLR  = 32'h230;
    localparam int unsigned OFF_MBX_LO   = 32'h510;
    localparam int unsigned OFF_MBX_HI   = 32'h514;
    localparam int unsigned OFF_CST      = 32'h518;

    localparam int DW       = 32;
    localparam int HALF_W   = DW / 2;
    localparam int BYTE_W   = 8;
    localparam int BIT_BASE = 24;     // lowest active bit of control words
    localparam int IB_N     = 5;      // inbound request bits
    localparam int OB_N     = 2;      // outbound flags and mask bits
    localparam int ERR_BIT  = 29;     // error pending position
    localparam int PAD_HI   = DW - BIT_BASE - OB_N;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_IRQ_STAT,
        SEL_IB_SET,
        SEL_IB_CLR,
        SEL_OB_SET,
        SEL_OB_CLR,
        SEL_MSK_SET,
        SEL_MSK_CLR,
        SEL_MBX_LO,
        SEL_MBX_HI,
        SEL_CST
    } dbr_sel_e;

    typedef struct packed {
        logic [DW-1:0]     mbx_lo;
        logic [DW-1:0]     mbx_hi;
        logic [HALF_W-1:0] cst_id;
        logic [HALF_W-1:0] cst_code;
        logic              err_pend;
        logic [BYTE_W-1:0] err_p0;
        logic [BYTE_W-1:0] err_p1;
        logic [DW-1:0]     rdata;
    } dbr_state_t;

endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic [AW-1:0] addr_i,
    output dbr_sel_e      sel_o
);

    always_comb begin
        case (addr_i)
            AW'(OFF_IRQ_STAT): sel_o = SEL_IRQ_STAT;
            AW'(OFF_IB_SET):   sel_o = SEL_IB_SET;
            AW'(OFF_IB_CLR):   sel_o = SEL_IB_CLR;
            AW'(OFF_OB_SET):   sel_o = SEL_OB_SET;
            AW'(OFF_OB_CLR):   sel_o = SEL_OB_CLR;
            AW'(OFF_MSK_SET):  sel_o = SEL_MSK_SET;
            AW'(OFF_MSK_CLR):  sel_o = SEL_MSK_CLR;
            AW'(OFF_MBX_LO):   sel_o = SEL_MBX_LO;
            AW'(OFF_MBX_HI):   sel_o = SEL_MBX_HI;
            AW'(OFF_CST):      sel_o = SEL_CST;
            default:           sel_o = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/dbr_bitbank.sv
// Set/clear bit register with two sources of each; any set beats any clear.
module dbr_bitbank #(
    parameter int           W   = 2,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] host_set_i,
    input  logic [W-1:0] host_clr_i,
    input  logic [W-1:0] dev_set_i,
    input  logic [W-1:0] dev_clr_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = (bits_q & ~(host_clr_i | dev_clr_i)) | host_set_i | dev_set_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) bits_q <= RST;
        else         bits_q <= bits_d;
    end

    assign q_o = bits_q;

endmodule

// File: rtl/dbr_regwin.sv
module dbr_regwin
    import dbr_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    input  logic [AW-1:0]     host_addr_i,
    input  logic [DW-1:0]     host_wdata_i,
    output logic [DW-1:0]     host_rdata_o,
    output logic              irq_o,
    output logic [IB_N-1:0]   ib_req_o,
    input  logic [IB_N-1:0]   ctl_ib_ack_i,
    output logic              init_busy_o,
    input  logic              ctl_init_done_i,
    input  logic [OB_N-1:0]   ctl_ob_set_i,
    input  logic              ctl_cst_post_i,
    input  logic [HALF_W-1:0] ctl_cst_id_i,
    input  logic [HALF_W-1:0] ctl_cst_code_i,
    input  logic              ctl_err_post_i,
    input  logic [BYTE_W-1:0] ctl_err_p0_i,
    input  logic [BYTE_W-1:0] ctl_err_p1_i,
    output logic [2*DW-1:0]   mbox_addr_o
);

    localparam logic [OB_N-1:0] MSK_RST  = '1;
    localparam logic [OB_N-1:0] DISMISS  = '1;

    dbr_sel_e   sel;
    dbr_state_t st_d, st_q;

    logic [IB_N-1:0] ib_q, ib_hset, ib_hclr;
    logic [OB_N-1:0] ob_q, ob_hset, ob_hclr, ob_dset;
    logic [OB_N-1:0] msk_q, msk_hset, msk_hclr;
    logic [0:0]      init_q, init_clr;
    logic [OB_N-1:0] pend;
    logic            err_pend_q;
    logic [IB_N-1:0] wr_ib_bits;
    logic [OB_N-1:0] wr_ob_bits;

    dbr_decode #(.AW(AW)) u_dec (
        .addr_i (host_addr_i),
        .sel_o  (sel)
    );

    // Write strobes for the bit banks
    always_comb begin
        wr_ib_bits = host_wdata_i[BIT_BASE +: IB_N];
        wr_ob_bits = host_wdata_i[BIT_BASE +: OB_N];
        ib_hset  = (host_wr_i && sel == SEL_IB_SET)  ? wr_ib_bits : '0;
        ib_hclr  = (host_wr_i && sel == SEL_IB_CLR)  ? wr_ib_bits : '0;
        ob_hset  = (host_wr_i && sel == SEL_OB_SET)  ? wr_ob_bits : '0;
        ob_hclr  = (host_wr_i && sel == SEL_OB_CLR)  ? wr_ob_bits : '0;
        msk_hset = (host_wr_i && sel == SEL_MSK_SET) ? wr_ob_bits : '0;
        msk_hclr = (host_wr_i && sel == SEL_MSK_CLR) ? wr_ob_bits : '0;
        ob_dset  = ctl_ob_set_i | {{(OB_N-1){1'b0}}, ctl_cst_post_i};
        init_clr = ctl_init_done_i;
    end

    dbr_bitbank #(.W(IB_N), .RST('0)) u_ib (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .host_set_i (ib_hset),
        .host_clr_i (ib_hclr),
        .dev_set_i  ('0),
        .dev_clr_i  (ctl_ib_ack_i),
        .q_o        (ib_q)
    );

    dbr_bitbank #(.W(OB_N), .RST('0)) u_ob (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .host_set_i (ob_hset),
        .host_clr_i (ob_hclr),
        .dev_set_i  (ob_dset),
        .dev_clr_i  ('0),
        .q_o        (ob_q)
    );

    dbr_bitbank #(.W(OB_N), .RST(MSK_RST)) u_msk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .host_set_i (msk_hset),
        .host_clr_i (msk_hclr),
        .dev_set_i  ('0),
        .dev_clr_i  ('0),
        .q_o        (msk_q)
    );

    dbr_bitbank #(.W(1), .RST(1'b1)) u_init (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .host_set_i (1'b0),
        .host_clr_i (1'b0),
        .dev_set_i  (1'b0),
        .dev_clr_i  (init_clr),
        .q_o        (init_q)
    );

    assign pend = ob_q & ~msk_q;

    // Next-state for the data registers and the read port
    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;

        if (host_wr_i && sel == SEL_MBX_LO) st_d.mbx_lo = host_wdata_i;
        if (host_wr_i && sel == SEL_MBX_HI) st_d.mbx_hi = host_wdata_i;

        if (ctl_cst_post_i) begin
            st_d.cst_id   = ctl_cst_id_i;
            st_d.cst_code = ctl_cst_code_i;
        end

        if (ctl_err_post_i) begin
            st_d.err_pend = 1'b1;
            st_d.err_p0   = ctl_err_p0_i;
            st_d.err_p1   = ctl_err_p1_i;
        end else if (host_wr_i && sel == SEL_OB_CLR && wr_ob_bits == DISMISS) begin
            st_d.err_pend = 1'b0;
        end

        if (host_rd_i) begin
            case (sel)
                SEL_IRQ_STAT: st_d.rdata = {{PAD_HI{1'b0}}, pend, {BIT_BASE{1'b0}}};
                SEL_IB_SET:   st_d.rdata = {{PAD_HI{1'b0}}, init_q, ib_q[0],
                                            {BIT_BASE{1'b0}}};
                SEL_OB_SET: begin
                    st_d.rdata                      = '0;
                    st_d.rdata[BIT_BASE +: OB_N]    = ob_q;
                    st_d.rdata[ERR_BIT]             = st_q.err_pend;
                end
                SEL_MSK_SET:  st_d.rdata = {{PAD_HI{1'b0}}, msk_q, {BIT_BASE{1'b0}}};
                SEL_MBX_LO:   st_d.rdata = {{HALF_W{1'b0}}, st_q.err_p1, st_q.err_p0};
                SEL_MBX_HI:   st_d.rdata = st_q.mbx_hi;
                SEL_CST:      st_d.rdata = {st_q.cst_code, st_q.cst_id};
                default:      st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign err_pend_q   = st_q.err_pend;
    assign host_rdata_o = st_q.rdata;
    assign irq_o        = |pend;
    assign ib_req_o     = ib_q;
    assign init_busy_o  = init_q[0];
    assign mbox_addr_o  = {st_q.mbx_hi, st_q.mbx_lo};

endmodule

// File: rtl/dbr_regwin_chk.sv
module dbr_regwin_chk
    import dbr_pkg::*;
#(
    parameter int AW = 11
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              host_wr_i,
    input logic [AW-1:0]     host_addr_i,
    input logic [DW-1:0]     host_wdata_i,
    input logic [IB_N-1:0]   ctl_ib_ack_i,
    input logic [OB_N-1:0]   ctl_ob_set_i,
    input logic              ctl_cst_post_i,
    input logic              ctl_err_post_i,
    input logic [IB_N-1:0]   ib_q,
    input logic [OB_N-1:0]   ob_q,
    input logic [OB_N-1:0]   msk_q,
    input logic [0:0]        init_q,
    input logic              err_pend_q,
    input logic              irq_o
);

    logic ring_hm, dismiss_wr;
    assign ring_hm    = host_wr_i && host_addr_i == AW'(OFF_IB_SET) && host_wdata_i[BIT_BASE];
    assign dismiss_wr = host_wr_i && host_addr_i == AW'(OFF_OB_CLR)
                        && host_wdata_i[BIT_BASE +: OB_N] == '1;

    a_r2_ring_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ring_hm |=> ib_q[0]);

    a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_ib_ack_i[0] && !ring_hm) |=> !ib_q[0]);

    a_r4_init_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !init_q[0] |=> !init_q[0]);

    a_r5_ctl_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_ob_set_i[1] |=> ob_q[1]);

    a_r7_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (ob_q != '0 && msk_q != '1));

    a_r8_err_dismiss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dismiss_wr && !ctl_err_post_i) |=> !err_pend_q);

    a_r8_err_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_err_post_i |=> err_pend_q);

    a_r10_post_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_cst_post_i |=> ob_q[0]);

endmodule

bind dbr_regwin dbr_regwin_chk #(.AW(AW)) u_chk (.*);

// File: tb/dbr_regwin_tb.sv
module dbr_regwin_tb;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          irq;
    logic [4:0]    ib_req;
    logic [4:0]    ib_ack = '0;
    logic          init_busy;
    logic          init_done = 1'b0;
    logic [1:0]    ob_set = '0;
    logic          cst_post = 1'b0;
    logic [15:0]   cst_id = '0, cst_code = '0;
    logic          err_post = 1'b0;
    logic [7:0]    err_p0 = '0, err_p1 = '0;
    logic [63:0]   mbox_addr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference state
    logic [4:0]  m_ib;
    logic [1:0]  m_ob, m_msk;
    logic        m_init, m_err;
    logic [7:0]  m_p0, m_p1;
    logic [15:0] m_id, m_code;
    logic [31:0] m_lo, m_hi;

    always #5 clk = ~clk;

    dbr_regwin #(.AW(AW)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .host_wr_i(host_wr), .host_rd_i(host_rd),
        .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
        .irq_o(irq), .ib_req_o(ib_req), .ctl_ib_ack_i(ib_ack), .init_busy_o(init_busy),
        .ctl_init_done_i(init_done), .ctl_ob_set_i(ob_set), .ctl_cst_post_i(cst_post),
        .ctl_cst_id_i(cst_id), .ctl_cst_code_i(cst_code), .ctl_err_post_i(err_post),
        .ctl_err_p0_i(err_p0), .ctl_err_p1_i(err_p1), .mbox_addr_o(mbox_addr)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [AW-1:0] a);
        case (a)
            11'h208: return {6'b0, m_ob & ~m_msk, 24'b0};
            11'h214: return {6'b0, m_init, m_ib[0], 24'b0};
            11'h224: return {2'b0, m_err, 3'b0, m_ob, 24'b0};
            11'h22C: return {6'b0, m_msk, 24'b0};
            11'h510: return {16'b0, m_p1, m_p0};
            11'h514: return m_hi;
            11'h518: return {m_code, m_id};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [AW-1:0] a);
        case (a)
            11'h208: return "R7 irq status read";
            11'h214: return "R2 inbound read";
            11'h224: return "R5/R8 outbound read";
            11'h22C: return "R6 mask read";
            11'h510: return "R8 error bytes read";
            11'h514: return "R9 mailbox high read";
            11'h518: return "R10 command status read";
            default: return "R11 unmapped read";
        endcase
    endfunction

    function automatic void model_reset();
        m_ib = '0; m_ob = '0; m_msk = 2'b11; m_init = 1'b1; m_err = 1'b0;
        m_p0 = '0; m_p1 = '0; m_id = '0; m_code = '0; m_lo = '0; m_hi = '0;
    endfunction

    // One cycle with a host write (optional) and controller events together
    task automatic step(bit wr, logic [AW-1:0] a, logic [31:0] d,
                        logic [4:0] ack, bit idone, logic [1:0] obs,
                        bit cpost, logic [15:0] cid, logic [15:0] ccode,
                        bit epost, logic [7:0] p0, logic [7:0] p1);
        logic [4:0] ibs, ibc;
        logic [1:0] os, oc, ms, mc;
        @(negedge clk);
        host_wr = wr; host_addr = a; host_wdata = d;
        ib_ack = ack; init_done = idone; ob_set = obs;
        cst_post = cpost; cst_id = cid; cst_code = ccode;
        err_post = epost; err_p0 = p0; err_p1 = p1;
        @(negedge clk);
        host_wr = 0; ib_ack = '0; init_done = 0; ob_set = '0;
        cst_post = 0; err_post = 0;
        ibs = (wr && a == 11'h214) ? d[28:24] : '0;
        ibc = ((wr && a == 11'h218) ? d[28:24] : '0) | ack;
        os  = ((wr && a == 11'h224) ? d[25:24] : '0) | obs | {1'b0, cpost};
        oc  = (wr && a == 11'h228) ? d[25:24] : '0;
        ms  = (wr && a == 11'h22C) ? d[25:24] : '0;
        mc  = (wr && a == 11'h230) ? d[25:24] : '0;
        m_ib  = (m_ib & ~ibc) | ibs;
        m_ob  = (m_ob & ~oc) | os;
        m_msk = (m_msk & ~mc) | ms;
        if (idone) m_init = 1'b0;
        if (wr && a == 11'h510) m_lo = d;
        if (wr && a == 11'h514) m_hi = d;
        if (cpost) begin m_id = cid; m_code = ccode; end
        if (epost) begin m_err = 1'b1; m_p0 = p0; m_p1 = p1; end
        else if (wr && a == 11'h228 && d[25:24] == 2'b11) m_err = 1'b0;
    endtask

    task automatic hwrite(logic [AW-1:0] a, logic [31:0] d);
        step(1, a, d, '0, 0, '0, 0, '0, '0, 0, '0, '0);
    endtask

    task automatic chk_read(logic [AW-1:0] a);
        @(negedge clk);
        host_rd = 1; host_addr = a;
        @(negedge clk);
        host_rd = 0;
        check(tag_of(a), {32'h0, host_rdata}, {32'h0, exp_read(a)});
    endtask

    task automatic chk_ports(string tag);
        check({tag, " R7 irq"}, {63'h0, irq}, {63'h0, |(m_ob & ~m_msk)});
        check({tag, " R2 ib_req"}, {59'h0, ib_req}, {59'h0, m_ib});
        check({tag, " R4 init_busy"}, {63'h0, init_busy}, {63'h0, m_init});
        check({tag, " R9 mailbox addr"}, mbox_addr, {m_hi, m_lo});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] addrs [12];
        void'($urandom(32'h5EED1234));
        addrs = '{11'h208, 11'h214, 11'h218, 11'h224, 11'h228, 11'h22C,
                  11'h230, 11'h510, 11'h514, 11'h518, 11'h000, 11'h5FC};
        model_reset();
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;

        // R1: reset state
        chk_ports("R1 reset");
        chk_read(11'h22C);
        chk_read(11'h214);
        chk_read(11'h224);
        chk_read(11'h208);

        // R11: unmapped read and write to read-only address
        chk_read(11'h3FC);
        hwrite(11'h208, 32'hFFFF_FFFF);
        chk_read(11'h208);
        chk_ports("R11 ro write");

        // R4: init done, then sticky
        step(0, '0, '0, '0, 1, '0, 0, '0, '0, 0, '0, '0);
        check("R4 init cleared", {63'h0, init_busy}, 64'h0);
        chk_read(11'h214);
        step(0, '0, '0, '0, 1, '0, 0, '0, '0, 0, '0, '0);
        chk_ports("R4 again");

        // R2: ring all, partial clear
        hwrite(11'h214, 32'h1F00_0000);
        check("R2 all requests", {59'h0, ib_req}, 64'h1F);
        chk_read(11'h214);
        hwrite(11'h218, 32'h0A00_0000);
        check("R2 partial clear", {59'h0, ib_req}, 64'h15);
        hwrite(11'h214, 32'h0000_0000);
        check("R2 zero write", {59'h0, ib_req}, 64'h15);

        // R3: ack and ring same bit in one cycle, ring wins; ack alone clears
        step(1, 11'h214, 32'h0100_0000, 5'b00001, 0, '0, 0, '0, '0, 0, '0, '0);
        check("R3 set wins", {59'h0, ib_req}, 64'h15);
        step(0, '0, '0, 5'b10001, 0, '0, 0, '0, '0, 0, '0, '0);
        check("R3 ack clears", {59'h0, ib_req}, 64'h04);

        // R5/R7: flag while masked, then unmask
        step(0, '0, '0, '0, 0, 2'b10, 0, '0, '0, 0, '0, '0);
        chk_read(11'h224);
        check("R7 masked irq", {63'h0, irq}, 64'h0);
        hwrite(11'h230, 32'h0200_0000);
        check("R7 unmasked irq", {63'h0, irq}, 64'h1);
        chk_read(11'h208);
        chk_read(11'h22C);
        // R5: controller set beats host clear
        step(1, 11'h228, 32'h0200_0000, '0, 0, 2'b10, 0, '0, '0, 0, '0, '0);
        check("R5 set wins", {63'h0, irq}, 64'h1);
        hwrite(11'h228, 32'h0200_0000);
        check("R5 host clear", {63'h0, irq}, 64'h0);
        chk_read(11'h224);

        // R8: error post, single-bit clear keeps it, full pattern dismisses
        step(0, '0, '0, '0, 0, '0, 0, '0, '0, 1, 8'h5A, 8'hC3);
        chk_read(11'h224);
        chk_read(11'h510);
        hwrite(11'h228, 32'h0100_0000);
        chk_read(11'h224);
        step(1, 11'h228, 32'h0300_0000, '0, 0, '0, 0, '0, '0, 1, 8'h11, 8'h22);
        chk_read(11'h224);
        hwrite(11'h228, 32'h0300_0000);
        chk_read(11'h224);

        // R9: mailbox address
        hwrite(11'h510, 32'hDEAD_0004);
        hwrite(11'h514, 32'h0000_00A5);
        check("R9 mailbox", mbox_addr, 64'h0000_00A5_DEAD_0004);
        chk_read(11'h514);
        chk_read(11'h510);

        // R10: command status post
        step(0, '0, '0, '0, 0, '0, 1, 16'h1234, 16'hBEEF, 0, '0, '0);
        chk_read(11'h518);
        chk_read(11'h224);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [AW-1:0] a;
            logic [31:0] d;
            op = $urandom_range(0, 3);
            a  = addrs[$urandom_range(0, 11)];
            d  = $urandom();
            if (op == 0)
                hwrite(a, d);
            else if (op == 1)
                step(1, a, d, 5'($urandom()), 0, 2'($urandom()),
                     ($urandom_range(0, 3) == 0), 16'($urandom()), 16'($urandom()),
                     ($urandom_range(0, 3) == 0), 8'($urandom()), 8'($urandom()));
            else if (op == 2)
                step(0, '0, '0, 5'($urandom()), 0, 2'($urandom()),
                     ($urandom_range(0, 1) == 0), 16'($urandom()), 16'($urandom()),
                     ($urandom_range(0, 1) == 0), 8'($urandom()), 8'($urandom()));
            else
                hwrite(a, {3'b0, 5'($urandom()), 24'($urandom())});
            chk_ports("random");
            chk_read(addrs[$urandom_range(0, 11)]);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule